// File: doc/BRIEF.md
# VGA Indexed Register Port Bank

This block holds the byte-wide configuration registers of a VGA-compatible display controller. Three register groups are reached through it: the sequencer group, the graphics group and the CRT group. Each group has an index port, which selects a register, and a data port, which reads or writes the selected register. A simple synchronous bus carries every access: one address, one write strobe, one read strobe and 8-bit data. Writes take effect on the clock edge where they are presented. Read data is a combinational function of the address and of the stored state.

A mapping bit in the miscellaneous output register moves the CRT index/data pair between the monochrome and the colour port addresses. The CRT group has several special behaviours. CRT registers 0 to 7 can be locked. Four registers hold fixed identification values. One register also writes a 2-bit field inside another register. The display start address and the raw contents of every register are driven out to the display logic.

Top module: `vga_regbank`

## Requirements
- R1: A write to the sequencer index port (0x3C4) stores only bits 2:0 of the data. A write to the graphics index port (0x3CE) stores only bits 3:0. Reading either index port returns the stored index, zero-extended to 8 bits.
- R2: A write to the sequencer data port (0x3C5) or the graphics data port (0x3CF) stores the data ANDed with a writable-bit mask chosen by the current index. The sequencer masks for indexes 0 to 7 are 03 3D 0F 3F 0E 00 00 FF. The graphics masks for indexes 0 to 8 are 0F 0F 0F 1F 03 7B 0F 0F FF, and indexes 9 to 15 have mask 00. Reading the data port returns the register selected by the current index.
- R3: A write to the active CRT index port stores bits 6:0 of the data. Reading that port returns the stored index with bit 7 as zero. Reading the active CRT data port returns the CRT register selected by the current index.
- R4: While bit 7 of CRT register 0x11 is 1, writes to CRT registers 0 to 6 have no effect. A write to CRT register 7 then changes only its bit 4. While bit 7 of register 0x11 is 0, these registers are written in full.
- R5: After reset, every register and index reads 0x00, except CRT 0x2D = 0x88, 0x2E = 0xB0, 0x2F = 0x01 and 0x30 = 0xE1.
- R6: Writes to CRT registers 0x2D to 0x30 are ignored, so these registers keep their reset values.
- R7: A write to CRT register 0x51 stores the full byte in register 0x51. It also copies data bits 1:0 into bits 3:2 of CRT register 0x69 and leaves the other bits of 0x69 unchanged.
- R8: disp_start_addr equals {CRT 0x69 bits 4:0, CRT 0x0C, CRT 0x0D}, most significant first.
- R9: The miscellaneous output register is written at 0x3C2 and read at 0x3CC. When its bit 0 is 1, the CRT pair is at 0x3D4/0x3D5. When bit 0 is 0, the pair is at 0x3B4/0x3B5. An access at the inactive pair is ignored on write and returns 0xFF on read.
- R10: seq_regs, gfx_regs and crt_regs carry the stored registers. Register n of a group occupies bits 8n+7 to 8n of its bus.
- R11: Reads change no state. bus_rdata is 0x00 while bus_rd is low. A read of an address that is not mapped returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | I/O port address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| disp_start_addr | output | 21 | Display start address |
| seq_regs | output | 64 | Raw sequencer registers |
| gfx_regs | output | 128 | Raw graphics registers |
| crt_regs | output | 1024 | Raw CRT registers |

## Verification
A bad stored index shows at the next read of its index port. It also shows as wrong data at the data port, one cycle after the index write. A wrong lock, identification or write-mask decision is visible on the raw register buses at the clock edge that follows the offending write. It shows in bus_rdata in the same cycle as the next read. The start address output follows any corruption of registers 0x0C, 0x0D or 0x69 one cycle after the write. A mapping error shows as 0xFF at the port that should respond, or as register changes made through the port that should be dead.

// File: rtl/vga_regbank_pkg.sv
// Shared constants, types and mask functions for the VGA register bank.
// Assumes a 16-bit I/O address space and byte-wide registers.
package vga_regbank_pkg;

    localparam int PORT_W = 16;
    typedef logic [PORT_W-1:0] port_t;

    localparam port_t P_SEQ_IDX  = 16'h03C4;
    localparam port_t P_SEQ_DAT  = 16'h03C5;
    localparam port_t P_GFX_IDX  = 16'h03CE;
    localparam port_t P_GFX_DAT  = 16'h03CF;
    localparam port_t P_MISC_WR  = 16'h03C2;
    localparam port_t P_MISC_RD  = 16'h03CC;
    localparam port_t P_CRT_IDX_M = 16'h03B4;
    localparam port_t P_CRT_DAT_M = 16'h03B5;
    localparam port_t P_CRT_IDX_C = 16'h03D4;
    localparam port_t P_CRT_DAT_C = 16'h03D5;

    // CRT register numbers with special behaviour
    localparam int CRI_LOCK_LAST = 7;
    localparam int CRI_LOCK_CTRL = 'h11;
    localparam int CRI_START_MID = 'h0C;
    localparam int CRI_START_LO  = 'h0D;
    localparam int CRI_ID_FIRST  = 'h2D;
    localparam int CRI_ID_LAST   = 'h30;
    localparam int CRI_EXT_SRC   = 'h51;
    localparam int CRI_EXT_DST   = 'h69;

    typedef enum logic {GRP_SEQ, GRP_GFX} grp_e;

    typedef struct packed {
        logic seq_idx;
        logic seq_dat;
        logic gfx_idx;
        logic gfx_dat;
        logic crt_idx;
        logic crt_dat;
        logic misc_wr;
        logic misc_rd;
        logic crt_dead;
    } port_sel_t;

    // Writable bits of a sequencer or graphics register
    function automatic logic [7:0] wr_mask(grp_e g, logic [3:0] i);
        logic [7:0] m;
        m = 8'h00;
        if (g == GRP_SEQ) begin
            case (i)
                4'd0: m = 8'h03;
                4'd1: m = 8'h3D;
                4'd2: m = 8'h0F;
                4'd3: m = 8'h3F;
                4'd4: m = 8'h0E;
                4'd7: m = 8'hFF;
                default: m = 8'h00;
            endcase
        end else begin
            case (i)
                4'd0, 4'd1, 4'd2, 4'd6, 4'd7: m = 8'h0F;
                4'd3: m = 8'h1F;
                4'd4: m = 8'h03;
                4'd5: m = 8'h7B;
                4'd8: m = 8'hFF;
                default: m = 8'h00;
            endcase
        end
        return m;
    endfunction

    // Reset value of a CRT register (identification bytes, else zero)
    function automatic logic [7:0] crt_reset_val(int i);
        logic [7:0] v;
        case (i)
            'h2D: v = 8'h88;
            'h2E: v = 8'hB0;
            'h2F: v = 8'h01;
            'h30: v = 8'hE1;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/vga_port_decode.sv
// Decodes the I/O address into one-hot port selects.
// Assumes the CRT mapping bit is stable during an access; strobes are applied by the caller.
module vga_port_decode
    import vga_regbank_pkg::*;
(
    input  port_t     addr,
    input  logic      color_map,
    output port_sel_t sel
);

    // Address match for every port; the CRT pair follows the mapping bit
    always_comb begin
        sel = '0;
        sel.seq_idx = (addr == P_SEQ_IDX);
        sel.seq_dat = (addr == P_SEQ_DAT);
        sel.gfx_idx = (addr == P_GFX_IDX);
        sel.gfx_dat = (addr == P_GFX_DAT);
        sel.misc_wr = (addr == P_MISC_WR);
        sel.misc_rd = (addr == P_MISC_RD);
        if (color_map) begin
            sel.crt_idx  = (addr == P_CRT_IDX_C);
            sel.crt_dat  = (addr == P_CRT_DAT_C);
            sel.crt_dead = (addr == P_CRT_IDX_M) || (addr == P_CRT_DAT_M);
        end else begin
            sel.crt_idx  = (addr == P_CRT_IDX_M);
            sel.crt_dat  = (addr == P_CRT_DAT_M);
            sel.crt_dead = (addr == P_CRT_IDX_C) || (addr == P_CRT_DAT_C);
        end
    end

endmodule

// File: rtl/vga_idx_group.sv
// One indexed register group (sequencer or graphics) with per-index write masks.
// Assumes index and data writes never occur in the same cycle; reset is synchronous, active low.
module vga_idx_group
    import vga_regbank_pkg::*;
#(
    parameter int   IDX_W = 3,
    parameter grp_e GRP   = GRP_SEQ
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        idx_we,
    input  logic                        dat_we,
    input  logic [7:0]                  wdata,
    output logic [IDX_W-1:0]            idx_o,
    output logic [7:0]                  rd_o,
    output logic [(1<<IDX_W)*8-1:0]     regs_o
);

    localparam int N = 1 << IDX_W;

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       regs [N];

    // Index register keeps only the low IDX_W bits
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata[IDX_W-1:0];
    end

    // Data write stores the masked value at the current index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= 8'h00;
        end else if (dat_we) begin
            regs[idx_q] <= wdata & wr_mask(GRP, 4'(idx_q));
        end
    end

    assign idx_o = idx_q;
    assign rd_o  = regs[idx_q];

    // Flatten the storage onto the raw output bus
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign regs_o[g*8 +: 8] = regs[g];
    end

    assert_idx_trunc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        idx_we |=> idx_o == $past(wdata[IDX_W-1:0]));

    assert_masked_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !idx_we) |=> rd_o == ($past(wdata) & wr_mask(GRP, 4'($past(idx_o)))));

endmodule

// File: rtl/vga_crt_bank.sv
// CRT register group: lock of registers 0-7, fixed identification bytes,
// extended field copy into register 0x69 and the display start address.
// Assumes IDX_W >= 7 so that every special register exists.
module vga_crt_bank
    import vga_regbank_pkg::*;
#(
    parameter int IDX_W = 7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     idx_we,
    input  logic                     dat_we,
    input  logic [7:0]               wdata,
    output logic [IDX_W-1:0]         idx_o,
    output logic [7:0]               rd_o,
    output logic [20:0]              start_addr_o,
    output logic [(1<<IDX_W)*8-1:0]  regs_o
);

    localparam int N = 1 << IDX_W;

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       regs [N];
    logic             locked, in_lock_range, is_id, is_ext, wr_full, wr_bit4;

    // Classify the write target at the current index
    always_comb begin
        locked        = regs[CRI_LOCK_CTRL][7];
        in_lock_range = (idx_q <= IDX_W'(CRI_LOCK_LAST));
        is_id         = (idx_q >= IDX_W'(CRI_ID_FIRST)) && (idx_q <= IDX_W'(CRI_ID_LAST));
        is_ext        = (idx_q == IDX_W'(CRI_EXT_SRC));
        wr_full       = dat_we && !is_id && !(locked && in_lock_range);
        wr_bit4       = dat_we && locked && (idx_q == IDX_W'(CRI_LOCK_LAST));
    end

    // Index register
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_we) idx_q <= wdata[IDX_W-1:0];
    end

    // Register storage with lock, read-only and field-copy rules
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) regs[i] <= crt_reset_val(i);
        end else begin
            if (wr_full) regs[idx_q] <= wdata;
            if (wr_bit4) regs[CRI_LOCK_LAST][4] <= wdata[4];
            if (wr_full && is_ext) regs[CRI_EXT_DST][3:2] <= wdata[1:0];
        end
    end

    assign idx_o        = idx_q;
    assign rd_o         = regs[idx_q];
    assign start_addr_o = {regs[CRI_EXT_DST][4:0], regs[CRI_START_MID], regs[CRI_START_LO]};

    // Flatten the storage onto the raw output bus
    for (genvar g = 0; g < N; g++) begin : g_flat
        assign regs_o[g*8 +: 8] = regs[g];
    end

    assert_lock_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && locked && idx_o < IDX_W'(CRI_LOCK_LAST)) |=> $stable(rd_o));

    assert_lock_bit4_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_o == IDX_W'(CRI_LOCK_LAST)) |=> rd_o[4] == $past(wdata[4]));

    assert_id_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        regs[CRI_ID_FIRST] == 8'h88 && regs[CRI_ID_FIRST+1] == 8'hB0 &&
        regs[CRI_ID_FIRST+2] == 8'h01 && regs[CRI_ID_LAST] == 8'hE1);

    assert_ext_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && idx_o == IDX_W'(CRI_EXT_SRC)) |=>
            regs[CRI_EXT_DST][3:2] == $past(wdata[1:0]) &&
            regs[CRI_EXT_DST][7:4] == $past(regs[CRI_EXT_DST][7:4]) &&
            regs[CRI_EXT_DST][1:0] == $past(regs[CRI_EXT_DST][1:0]));

endmodule

// File: rtl/vga_regbank.sv
// VGA register port bank: decodes bus accesses, holds the mapping register,
// and steers reads from the sequencer, graphics and CRT groups.
// Assumes at most one of bus_wr / bus_rd per cycle; reset is synchronous, active low.
module vga_regbank
    import vga_regbank_pkg::*;
#(
    parameter int SEQ_IDX_W = 3,
    parameter int GFX_IDX_W = 4,
    parameter int CR_IDX_W  = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [15:0]                  bus_addr,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [7:0]                   bus_wdata,
    output logic [7:0]                   bus_rdata,
    output logic [20:0]                  disp_start_addr,
    output logic [(1<<SEQ_IDX_W)*8-1:0]  seq_regs,
    output logic [(1<<GFX_IDX_W)*8-1:0]  gfx_regs,
    output logic [(1<<CR_IDX_W)*8-1:0]   crt_regs
);

    port_sel_t            sel;
    logic [7:0]           misc_q;
    logic [SEQ_IDX_W-1:0] seq_idx;
    logic [GFX_IDX_W-1:0] gfx_idx;
    logic [CR_IDX_W-1:0]  crt_idx;
    logic [7:0]           seq_rd, gfx_rd, crt_rd;

    vga_port_decode u_dec (
        .addr      (bus_addr),
        .color_map (misc_q[0]),
        .sel       (sel)
    );

    // Miscellaneous output register; bit 0 picks the CRT port pair
    always_ff @(posedge clk) begin
        if (!rst_n)                     misc_q <= 8'h00;
        else if (bus_wr && sel.misc_wr) misc_q <= bus_wdata;
    end

    vga_idx_group #(.IDX_W(SEQ_IDX_W), .GRP(GRP_SEQ)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (bus_wr && sel.seq_idx),
        .dat_we (bus_wr && sel.seq_dat),
        .wdata  (bus_wdata),
        .idx_o  (seq_idx),
        .rd_o   (seq_rd),
        .regs_o (seq_regs)
    );

    vga_idx_group #(.IDX_W(GFX_IDX_W), .GRP(GRP_GFX)) u_gfx (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_we (bus_wr && sel.gfx_idx),
        .dat_we (bus_wr && sel.gfx_dat),
        .wdata  (bus_wdata),
        .idx_o  (gfx_idx),
        .rd_o   (gfx_rd),
        .regs_o (gfx_regs)
    );

    vga_crt_bank #(.IDX_W(CR_IDX_W)) u_crt (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx_we       (bus_wr && sel.crt_idx),
        .dat_we       (bus_wr && sel.crt_dat),
        .wdata        (bus_wdata),
        .idx_o        (crt_idx),
        .rd_o         (crt_rd),
        .start_addr_o (disp_start_addr),
        .regs_o       (crt_regs)
    );

    // Read steering; unmapped and inactive ports return all ones
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd) begin
            bus_rdata = 8'hFF;
            if (sel.seq_idx)      bus_rdata = 8'(seq_idx);
            else if (sel.seq_dat) bus_rdata = seq_rd;
            else if (sel.gfx_idx) bus_rdata = 8'(gfx_idx);
            else if (sel.gfx_dat) bus_rdata = gfx_rd;
            else if (sel.crt_idx) bus_rdata = 8'(crt_idx);
            else if (sel.crt_dat) bus_rdata = crt_rd;
            else if (sel.misc_rd) bus_rdata = misc_q;
        end
    end

    assert_dead_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.crt_dead) |=> $stable(crt_regs) && $stable(crt_idx));

    assert_misc_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel.misc_wr) |=> misc_q == $past(bus_wdata));

    assert_read_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr) |=> $stable(seq_regs) && $stable(gfx_regs) && $stable(crt_regs));

endmodule

// File: tb/vga_regbank_tb.sv
`timescale 1ns/1ps
module vga_regbank_tb_top;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = 16'h0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = 8'h0;
    logic [7:0]    bus_rdata;
    logic [20:0]   disp_start_addr;
    logic [63:0]   seq_regs;
    logic [127:0]  gfx_regs;
    logic [1023:0] crt_regs;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;
    logic [15:0] cri_port = 16'h03B4;
    logic [15:0] crd_port = 16'h03B5;

    always #2.5 clk = ~clk;

    vga_regbank dut_i (
        .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_wr (bus_wr),
        .bus_rd (bus_rd), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .disp_start_addr (disp_start_addr), .seq_regs (seq_regs),
        .gfx_regs (gfx_regs), .crt_regs (crt_regs)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic cr_wr(input logic [7:0] i, input logic [7:0] d);
        wr(cri_port, i);
        wr(crd_port, d);
    endtask

    task automatic cr_rd(input logic [7:0] i, output logic [7:0] d);
        wr(cri_port, i);
        rd(crd_port, d);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        cr_rd(8'h2D, v); check("R5 CR2D", v, 8'h88);
        cr_rd(8'h2E, v); check("R5 CR2E", v, 8'hB0);
        cr_rd(8'h2F, v); check("R5 CR2F", v, 8'h01);
        cr_rd(8'h30, v); check("R5 CR30", v, 8'hE1);
        rd(16'h03C5, v); check("R5 SR0", v, 8'h00);
        check("R5 gfx raw", gfx_regs, 128'h0);
        check("R11 idle rdata", bus_rdata, 8'h00);
    endtask

    task automatic t_seq_gfx;
        logic [7:0] v;
        wr(16'h03C4, 8'hFD); rd(16'h03C4, v); check("R1 SR idx", v, 8'h05);
        wr(16'h03C4, 8'h01); wr(16'h03C5, 8'hFF);
        rd(16'h03C5, v); check("R2 SR1 mask", v, 8'h3D);
        wr(16'h03CE, 8'h1B); rd(16'h03CE, v); check("R1 GR idx", v, 8'h0B);
        wr(16'h03CE, 8'h05); wr(16'h03CF, 8'hFF);
        rd(16'h03CF, v); check("R2 GR5 mask", v, 8'h7B);
        wr(16'h03CE, 8'h08); wr(16'h03CF, 8'hA5);
        rd(16'h03CF, v); check("R2 GR8 full", v, 8'hA5);
        wr(16'h03C4, 8'h03); wr(16'h03C5, 8'hFF);
        @(negedge clk); check("R10 seq raw SR3", seq_regs[3*8 +: 8], 8'h3F);
        check("R10 gfx raw GR5", gfx_regs[5*8 +: 8], 8'h7B);
    endtask

    task automatic t_lock;
        logic [7:0] v;
        cr_wr(8'h11, 8'h80);
        cr_wr(8'h03, 8'h55); cr_rd(8'h03, v); check("R4 CR3 locked", v, 8'h00);
        cr_wr(8'h07, 8'hFF); cr_rd(8'h07, v); check("R4 CR7 bit4 only", v, 8'h10);
        cr_wr(8'h11, 8'h00);
        cr_wr(8'h03, 8'h55); cr_rd(8'h03, v); check("R4 CR3 unlocked", v, 8'h55);
        cr_wr(8'h07, 8'hEF); cr_rd(8'h07, v); check("R4 CR7 unlocked", v, 8'hEF);
    endtask

    task automatic t_id;
        logic [7:0] v;
        cr_wr(8'h2E, 8'h00); cr_rd(8'h2E, v); check("R6 CR2E kept", v, 8'hB0);
        cr_wr(8'h30, 8'h12); cr_rd(8'h30, v); check("R6 CR30 kept", v, 8'hE1);
    endtask

    task automatic t_ext_start;
        logic [7:0] v;
        cr_wr(8'h69, 8'hF3);
        cr_wr(8'h51, 8'h02);
        cr_rd(8'h69, v); check("R7 CR69 field", v, 8'hFB);
        cr_rd(8'h51, v); check("R7 CR51 stored", v, 8'h02);
        cr_wr(8'h0C, 8'h12); cr_wr(8'h0D, 8'h34);
        @(negedge clk); check("R8 start addr", disp_start_addr, 21'h1B1234);
        cr_wr(8'h13, 8'h5A);
        @(negedge clk); check("R10 crt raw CR13", crt_regs[8'h13*8 +: 8], 8'h5A);
    endtask

    task automatic t_cr_idx_and_reads;
        logic [7:0] v, w;
        wr(cri_port, 8'hAD); rd(cri_port, v); check("R3 CR idx 7 bits", v, 8'h2D);
        rd(crd_port, v); rd(crd_port, w); check("R11 repeat read", w, v);
        check("R3 CR data via idx", v, 8'h88);
        rd(16'h0300, v); check("R11 unmapped", v, 8'hFF);
    endtask

    task automatic t_mapping;
        logic [7:0] v;
        cr_wr(8'h20, 8'h00);
        rd(16'h03D5, v); check("R9 colour dead", v, 8'hFF);
        wr(16'h03D4, 8'h21); wr(16'h03D5, 8'h99);
        rd(16'h03B4, v); check("R9 idx untouched", v, 8'h20);
        @(negedge clk); check("R9 CR21 untouched", crt_regs[8'h21*8 +: 8], 8'h00);
        wr(16'h03C2, 8'h01); rd(16'h03CC, v); check("R9 misc readback", v, 8'h01);
        rd(16'h03B5, v); check("R9 mono dead", v, 8'hFF);
        rd(16'h03D4, v); check("R9 colour idx", v, 8'h20);
        cri_port = 16'h03D4; crd_port = 16'h03D5;
        cr_wr(8'h22, 8'h6C); cr_rd(8'h22, v); check("R9 colour data", v, 8'h6C);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_seq_gfx();
        t_lock();
        t_id();
        t_ext_start();
        t_cr_idx_and_reads();
        t_mapping();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule